// File: doc/BRIEF.md
# Fractional Phase-Jump Sigma-Delta Generator

This block is a first-order sigma-delta modulator for a phase-switching clock synthesizer. It runs on the divider output clock and makes one update per divider cycle. Its input is a fixed-point jump word made of an integer part and a fraction. On each edge it emits a small whole-number jump count. Over time, the mean of that count equals the jump word divided by the accumulator modulus. The fraction goes into a wrapping accumulator, and each time the accumulator wraps the count gains one. The integer part is added to the count on every cycle.

Because of the integer part, the word may exceed the accumulator modulus. With the default five-bit fraction and one integer bit, a word of 19 gives a stream of 0s and 1s that averages 19/32. A word of 38 gives a stream of 1s and 2s that averages 38/32. The two settings suit a ten-phase and a twenty-phase selector driven for about the same frequency offset. A separate profile source sweeps the jump word and is not part of this block.

Top module: `sd_jump_gen`

## Requirements
- R1: While reset is low, the jump count is 0 and the accumulator is cleared. With the word held at 1 after reset, the count stays 0 for 31 clock edges and reads 1 after the 32nd edge.
- R2: The jump word is split by bit position. Bit 5 is the integer part and bits 4:0 are the fraction. Over 32 cycles with the word held, exactly as many outputs as the fraction value equal the integer part plus one.
- R3: Each rising edge registers a new count equal to the integer part plus the carry out of (accumulator + fraction). On the same edge the accumulator takes (accumulator + fraction) mod 32. The count is visible after that edge.
- R4: Every count is either the integer part or the integer part plus one, so it always lies in 0..2.
- R5: A jump word of 0 gives a count of 0 on every cycle.
- R6: A jump word whose fraction is zero (for example 32) gives a count equal to the integer part on every cycle.
- R7: Over any 32 consecutive cycles with the jump word held, the counts add up to exactly the jump word.
- R8: A change of jump word does not clear the accumulator. The residue left by the old word carries into the sequence for the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider output clock, one update per edge |
| rstN | input | 1 | Asynchronous active-low reset |
| jumpWord | input | 6 | Integer bit 5 and fraction bits 4:0 |
| jumpCount | output | 2 | Registered phase jump count, 0..2 |

## Verification
The assertions check on every cycle that the count stays within one step of the integer part. They also check that zero and pure-integer words give constant counts, and that each completed 32-cycle window with the word held sums exactly to the word. Only the bench scenarios can show the exact order of the carries against an arithmetic model, the residue carried across a word change, and the reset state observed at the output. The bench sweeps all 64 jump words.

// File: rtl/sd_jump_gen_pkg.sv
package sd_jump_gen_pkg;

  parameter int DEF_FRAC_W = 5;
  parameter int DEF_INT_W  = 1;

  typedef struct packed {
    logic addEn;   // fraction is nonzero: accumulator advances and may carry
    logic intOnly; // fraction is zero: count is the integer part alone
  } strobe_t;

endpackage

// File: rtl/sd_jump_ctrl.sv
module sd_jump_ctrl #(
  parameter int FRAC_W = sd_jump_gen_pkg::DEF_FRAC_W
) (
  input  logic [FRAC_W-1:0]            fracPart,
  output sd_jump_gen_pkg::strobe_t     strobes
);

  always_comb begin
    strobes.addEn   = |fracPart;
    strobes.intOnly = ~(|fracPart);
  end

endmodule

// File: rtl/sd_jump_dp.sv
module sd_jump_dp #(
  parameter int FRAC_W = sd_jump_gen_pkg::DEF_FRAC_W,
  parameter int INT_W  = sd_jump_gen_pkg::DEF_INT_W,
  parameter int OUT_W  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [FRAC_W-1:0]            fracPart,
  input  logic [INT_W-1:0]             intPart,
  input  sd_jump_gen_pkg::strobe_t     strobes,
  output logic [OUT_W-1:0]             jumpCount
);

  logic [FRAC_W-1:0] accQ;
  logic [FRAC_W:0]   sumWide;
  logic              carry;
  logic [OUT_W-1:0]  intExt;
  logic [OUT_W-1:0]  nextCount;

  always_comb begin
    sumWide   = {1'b0, accQ} + {1'b0, fracPart};
    carry     = sumWide[FRAC_W] & strobes.addEn;
    intExt    = OUT_W'(intPart);
    nextCount = strobes.intOnly ? intExt : (intExt + OUT_W'(carry));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      jumpCount <= '0;
    end else begin
      if (strobes.addEn) begin
        accQ <= sumWide[FRAC_W-1:0];
      end
      jumpCount <= nextCount;
    end
  end

endmodule

// File: rtl/sd_jump_gen.sv
module sd_jump_gen #(
  parameter int FRAC_W = sd_jump_gen_pkg::DEF_FRAC_W,
  parameter int INT_W  = sd_jump_gen_pkg::DEF_INT_W,
  localparam int WORD_W = FRAC_W + INT_W,
  localparam int OUT_W  = $clog2((1 << INT_W) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] jumpWord,
  output logic [OUT_W-1:0]  jumpCount
);

  sd_jump_gen_pkg::strobe_t strobes;
  logic [FRAC_W-1:0] fracPart;
  logic [INT_W-1:0]  intPart;

  assign fracPart = jumpWord[FRAC_W-1:0];
  assign intPart  = jumpWord[WORD_W-1:FRAC_W];

  sd_jump_ctrl #(.FRAC_W(FRAC_W)) ctrl_i (
    .fracPart (fracPart),
    .strobes  (strobes)
  );

  sd_jump_dp #(.FRAC_W(FRAC_W), .INT_W(INT_W), .OUT_W(OUT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .fracPart  (fracPart),
    .intPart   (intPart),
    .strobes   (strobes),
    .jumpCount (jumpCount)
  );

endmodule

// File: rtl/sd_jump_gen_chk.sv
module sd_jump_gen_chk #(
  parameter int FRAC_W = 5,
  parameter int INT_W  = 1,
  localparam int WORD_W = FRAC_W + INT_W,
  localparam int OUT_W  = $clog2((1 << INT_W) + 1),
  localparam int MOD    = 1 << FRAC_W,
  localparam int CNT_W  = FRAC_W + 1,
  localparam int SUM_W  = WORD_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] jumpWord,
  input logic [OUT_W-1:0]  jumpCount
);

  logic              lagValid;
  logic [WORD_W-1:0] lagWord;
  logic [WORD_W-1:0] winWord;
  logic [CNT_W-1:0]  winCnt;
  logic [SUM_W-1:0]  winSum;
  logic [OUT_W-1:0]  lagInt;

  assign lagInt = OUT_W'(lagWord[WORD_W-1:FRAC_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lagValid <= 1'b0;
      lagWord  <= '0;
      winWord  <= '0;
      winCnt   <= '0;
      winSum   <= '0;
    end else begin
      lagWord  <= jumpWord;
      lagValid <= 1'b1;
      if (lagValid) begin
        if (winCnt == '0 || winCnt == CNT_W'(MOD) || lagWord != winWord) begin
          winCnt  <= CNT_W'(1);
          winSum  <= SUM_W'(jumpCount);
          winWord <= lagWord;
        end else begin
          winCnt <= winCnt + 1'b1;
          winSum <= winSum + SUM_W'(jumpCount);
        end
      end
    end
  end

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    lagValid |-> (jumpCount == lagInt || jumpCount == lagInt + 1'b1));

  // R5
  zero_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lagValid && lagWord == '0) |-> jumpCount == '0);

  // R6
  whole_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lagValid && lagWord[FRAC_W-1:0] == '0) |-> jumpCount == lagInt);

  // R7
  window_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winCnt == CNT_W'(MOD)) |-> winSum == SUM_W'(winWord));

endmodule

bind sd_jump_gen sd_jump_gen_chk #(.FRAC_W(FRAC_W), .INT_W(INT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .jumpWord  (jumpWord),
  .jumpCount (jumpCount)
);

// File: tb/sd_jump_gen_tb_top.sv
`timescale 1ns/1ps
module sd_jump_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] jumpWord = '0;
  logic [1:0] jumpCount;

  int checks = 0;
  int errors = 0;
  int modelAcc = 0;
  int expCount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sd_jump_gen dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .jumpWord  (jumpWord),
    .jumpCount (jumpCount)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock edge; model follows R3, sampling at the following falling edge
  task automatic step();
    int f;
    int i;
    @(posedge clk);
    f = int'(jumpWord[4:0]);
    i = int'(jumpWord[5]);
    expCount = i + ((modelAcc + f) >= 32 ? 1 : 0);
    modelAcc = (modelAcc + f) % 32;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 count in reset", int'(jumpCount), 0);
    modelAcc = 0;
    rstN = 1'b1;
  endtask

  initial begin
    do_reset();

    // R1: accumulator starts from zero
    jumpWord = 6'd1;
    for (int k = 1; k <= 32; k++) begin
      step();
      check(k == 32 ? "R1 first carry" : "R1 no carry yet", int'(jumpCount), k == 32 ? 1 : 0);
    end

    // exhaustive sweep over all jump words
    for (int a = 0; a < 64; a++) begin
      int sum;
      int ups;
      sum = 0;
      ups = 0;
      jumpWord = 6'(a);
      for (int k = 0; k < 32; k++) begin
        step();
        if (a == 0)
          check("R5 zero word", int'(jumpCount), 0);
        else if ((a % 32) == 0)
          check("R6 whole word", int'(jumpCount), a / 32);
        else
          check("R3 per-cycle count", int'(jumpCount), expCount);
        check("R4 range", (int'(jumpCount) == a / 32 || int'(jumpCount) == a / 32 + 1) ? 1 : 0, 1);
        sum += int'(jumpCount);
        if (int'(jumpCount) == a / 32 + 1) ups++;
      end
      check("R7 window sum", sum, a);
      check("R2 carry count equals fraction", ups, a % 32);
    end

    // R8: residue survives a word change
    do_reset();
    jumpWord = 6'd19;
    for (int k = 0; k < 7; k++) begin
      step();
      check("R8 before change", int'(jumpCount), expCount);
    end
    jumpWord = 6'd38;
    for (int k = 0; k < 40; k++) begin
      step();
      check("R8 after change", int'(jumpCount), expCount);
    end
    jumpWord = 6'd5;
    for (int k = 0; k < 40; k++) begin
      step();
      check("R8 second change", int'(jumpCount), expCount);
    end

    // R7 from a non-zero start with 38
    jumpWord = 6'd38;
    begin
      int sum;
      sum = 0;
      for (int k = 0; k < 32; k++) begin
        step();
        sum += int'(jumpCount);
      end
      check("R7 window sum 38 offset start", sum, 38);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule